// File: doc/BRIEF.md
# Sixty-Four-Step PWM Dimming Generator

This block turns a 6-bit duty code into a single LED enable waveform. Each PWM period has 64 equal steps. Each step lasts a power-of-two number of oscillator clocks, and a 2-bit divide field selects that number. A code of zero keeps the LEDs dark. Any other code k lights them for the first k+1 steps of every period. The all-ones code lights them for the whole period. The surrounding logic supplies the code from whichever duty register is currently selected.

The block samples the duty code and the divide field only on a period boundary, so a change in the middle of a period never cuts a pulse short. A standby input stops the waveform and the counters at once but keeps the latched code. When standby is released, or reset is removed, a fresh period starts on the next clock edge, using the inputs presented at that edge.

Top module: `pwm_dimmer`

## Requirements
- R1: While `rst` is high, and in the cycle that follows, `pwm_out` is low. Reset clears the step prescaler and the step counter.
- R2: A latched duty code of 0 keeps `pwm_out` low for every cycle of the period.
- R3: A latched nonzero code k below the maximum drives `pwm_out` high for steps 0 through k of the period and low for steps k+1 through 63. The high time is one contiguous run of (k+1)·2^(PRE_BASE+N) clocks at the start of the period.
- R4: The all-ones code (63) keeps `pwm_out` high in every cycle, with no low cycle between consecutive periods.
- R5: With divide value N (0..3), every step lasts 2^(PRE_BASE+N) clocks (PRE_BASE = 3 by default), so one period lasts 64·2^(3+N) clocks.
- R6: Changes to `duty_code` or `div_sel` in the middle of a period have no effect on that period. They take effect from the next period boundary.
- R7: `pwm_out` is low in the cycle after a clock edge that sees `standby` high, and stays low while `standby` is high. The first edge with `standby` low starts a new period at step 0, using the code and divide value presented at that edge.
- R8: After reset, the first edge with `rst` low starts a period at step 0, using the inputs presented at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| standby | input | 1 | Halts the waveform and the counters while high |
| div_sel | input | DIV_W (2) | Step length exponent N; each step is 2^(PRE_BASE+N) clocks |
| duty_code | input | CODE_W (6) | Duty code from the selected duty register |
| pwm_out | output | 1 | LED enable waveform |

## Verification
The bench builds the block with its default parameters: a 6-bit code, a 2-bit divide field and a base exponent of 3. With these values the exact period lengths of 512, 1024, 2048 and 4096 clocks are checked cycle by cycle. Every divide value is used, together with the zero, smallest, mid-range and all-ones codes. Periods run back to back, so the wrap from step 63 to step 0 and the boundary latch are exercised each time. Standby and reset are also applied in the middle of a period.

// File: rtl/pwm_dim_pkg.sv
package pwm_dim_pkg;

   // Number of clocks per step for a given base exponent and divide value
   function automatic int unsigned step_clocks(input int unsigned base, input int unsigned n);
      return 32'd1 << (base + n);
   endfunction

endpackage

// File: rtl/pwm_dim_prescaler.sv
module pwm_dim_prescaler #(
   parameter int DIV_W    = 2,
   parameter int PRE_BASE = 3,
   parameter int CNT_W    = PRE_BASE + (1 << DIV_W) - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick,
   output logic [CNT_W-1:0] cnt
);
   localparam int NDIV = 1 << DIV_W;

   logic [CNT_W-1:0] lim [NDIV];

   // One terminal count per divide value: 2^(PRE_BASE+i) - 1
   for (genvar i = 0; i < NDIV; i++) begin : g_lim
      localparam int SH = CNT_W - PRE_BASE - i;
      assign lim[i] = {CNT_W{1'b1}} >> SH;
   end

   assign tick = run && (cnt == lim[div]);

   always_ff @(posedge clk) begin
      if (rst || !run)  cnt <= '0;
      else if (tick)    cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pwm_dim_stepctr.sv
module pwm_dim_stepctr #(
   parameter int CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run,
   input  logic              tick,
   output logic [CODE_W-1:0] step,
   output logic              last
);
   assign last = (step == {CODE_W{1'b1}});

   always_ff @(posedge clk) begin
      if (rst || !run) step <= '0;
      else if (tick)   step <= step + 1'b1;
   end
endmodule

// File: rtl/pwm_dim_shaper.sv
module pwm_dim_shaper #(
   parameter int CODE_W = 6,
   parameter int DIV_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              standby,
   input  logic              tick,
   input  logic              last,
   input  logic [CODE_W-1:0] step,
   input  logic [CODE_W-1:0] duty_in,
   input  logic [DIV_W-1:0]  div_in,
   output logic              run,
   output logic [CODE_W-1:0] code,
   output logic [DIV_W-1:0]  div,
   output logic              pwm
);
   logic boundary;

   assign boundary = !run || (tick && last);

   always_ff @(posedge clk) begin
      if (rst) begin
         run  <= 1'b0;
         code <= '0;
         div  <= '0;
      end else if (standby) begin
         run  <= 1'b0;
      end else if (boundary) begin
         run  <= 1'b1;
         code <= duty_in;
         div  <= div_in;
      end
   end

   assign pwm = run && (code != '0) && (step <= code);
endmodule

// File: rtl/pwm_dimmer.sv
module pwm_dimmer #(
   parameter int CODE_W   = 6,
   parameter int DIV_W    = 2,
   parameter int PRE_BASE = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              standby,
   input  logic [DIV_W-1:0]  div_sel,
   input  logic [CODE_W-1:0] duty_code,
   output logic              pwm_out
);
   localparam int CNT_W = PRE_BASE + (1 << DIV_W) - 1;

   if (CODE_W < 2) begin : g_bad_code
      $error("pwm_dimmer: CODE_W must be at least 2");
   end
   if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div
      $error("pwm_dimmer: DIV_W must be 1..3");
   end
   if (PRE_BASE < 0 || CNT_W > 24) begin : g_bad_base
      $error("pwm_dimmer: PRE_BASE out of range");
   end

   logic              run_q;
   logic              step_tick;
   logic              step_last;
   logic [CNT_W-1:0]  pre_q;
   logic [CODE_W-1:0] step_q;
   logic [CODE_W-1:0] code_q;
   logic [DIV_W-1:0]  div_q;

   pwm_dim_prescaler #(.DIV_W(DIV_W), .PRE_BASE(PRE_BASE), .CNT_W(CNT_W)) pre_i (
      .clk(clk), .rst(rst), .run(run_q), .div(div_q), .tick(step_tick), .cnt(pre_q)
   );

   pwm_dim_stepctr #(.CODE_W(CODE_W)) stp_i (
      .clk(clk), .rst(rst), .run(run_q), .tick(step_tick), .step(step_q), .last(step_last)
   );

   pwm_dim_shaper #(.CODE_W(CODE_W), .DIV_W(DIV_W)) shp_i (
      .clk(clk), .rst(rst), .standby(standby), .tick(step_tick), .last(step_last),
      .step(step_q), .duty_in(duty_code), .div_in(div_sel),
      .run(run_q), .code(code_q), .div(div_q), .pwm(pwm_out)
   );
endmodule

// File: rtl/pwm_dimmer_chk.sv
module pwm_dimmer_chk #(
   parameter int CODE_W   = 6,
   parameter int DIV_W    = 2,
   parameter int PRE_BASE = 3,
   parameter int CNT_W    = 6
) (
   input logic              clk,
   input logic              rst,
   input logic              standby,
   input logic              pwm_out,
   input logic              tick,
   input logic              last,
   input logic              run,
   input logic [CNT_W-1:0]  pre,
   input logic [CODE_W-1:0] code,
   input logic [DIV_W-1:0]  div
);
   // R1: output low after a reset edge
   assert_reset_low_R1: assert property (@(posedge clk) rst |=> !pwm_out);

   // R7: output low after an edge that sees standby
   assert_standby_low_R7: assert property (@(posedge clk) disable iff (rst)
      standby |=> !pwm_out);

   // R6: latched code and divide only move on a period boundary
   assert_latch_stable_R6: assert property (@(posedge clk) disable iff (rst)
      (run && !standby && !(tick && last)) |=> ($stable(code) && $stable(div)));

   // R5: prescaler never exceeds the step length chosen by the latched divide
   assert_step_len_R5: assert property (@(posedge clk) disable iff (rst)
      ({{(32-CNT_W){1'b0}}, pre} < pwm_dim_pkg::step_clocks(PRE_BASE, 32'(div))));

   // R3: the high run ends only on a step boundary
   assert_fall_on_step_R3: assert property (@(posedge clk) disable iff (rst)
      ($fell(pwm_out) && !$past(standby) && !$past(rst)) |-> $past(tick));
endmodule

bind pwm_dimmer pwm_dimmer_chk #(
   .CODE_W(CODE_W), .DIV_W(DIV_W), .PRE_BASE(PRE_BASE), .CNT_W(CNT_W)
) chk_i (
   .clk(clk), .rst(rst), .standby(standby), .pwm_out(pwm_out), .tick(step_tick),
   .last(step_last), .run(run_q), .pre(pre_q), .code(code_q), .div(div_q)
);

// File: tb/pwm_dimmer_tb_top.sv
module pwm_dimmer_tb_top;
   typedef struct {
      logic  exp;
      string req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       standby = 1'b0;
   logic [1:0] div_sel = '0;
   logic [5:0] duty_code = '0;
   logic       pwm_out;

   item_t q[$];
   int    n_run  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;

   always #2 clk = ~clk;

   pwm_dimmer #(.CODE_W(6), .DIV_W(2), .PRE_BASE(3)) dut_i (
      .clk(clk), .rst(rst), .standby(standby), .div_sel(div_sel),
      .duty_code(duty_code), .pwm_out(pwm_out)
   );

   // Monitor: compares each output cycle with the expected queue
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         n_run++;
         if (pwm_out !== it.exp) begin
            n_fail++;
            $display("FAIL %s: pwm_out=%b expected %b at %0t", it.req, pwm_out, it.exp, $time);
         end
      end
   end

   task automatic cyc(input logic e, input string req);
      item_t it;
      it.exp = e;
      it.req = req;
      q.push_back(it);
      @(posedge clk);
      #1;
   endtask

   // Drives one period (or its first ncyc clocks); glitch_at changes inputs mid-period
   task automatic run_period(input int code, input int dv, input int glitch_at,
                             input int ncyc, input string req);
      int len = 1 << (3 + dv);
      int tot = (ncyc > 0) ? ncyc : 64 * len;
      duty_code = code[5:0];
      div_sel   = dv[1:0];
      for (int i = 0; i < tot; i++) begin
         if (i == glitch_at) begin
            duty_code = ~code[5:0];
            div_sel   = ~dv[1:0];
         end
         cyc((code != 0) && ((i / len) <= code), req);
      end
   endtask

   task automatic finish_sim();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         finish_sim();
      end
   end

   initial begin
      // R1: reset holds output low
      #1;
      rst = 1'b1;
      duty_code = 6'd63;
      for (int i = 0; i < 4; i++) cyc(1'b0, "R1");
      rst = 1'b0;
      // R8, R2: first period starts at once; code 0 stays dark
      run_period(0, 0, -1, 0, "R8_R2");
      // R3, R5: small codes and each divide value
      run_period(1, 0, -1, 0, "R3_R5");
      run_period(2, 1, -1, 0, "R3_R5");
      run_period(33, 2, -1, 0, "R3_R5");
      // R4: full duty over two back-to-back periods
      run_period(63, 0, -1, 0, "R4");
      run_period(63, 0, -1, 0, "R4");
      // R6: mid-period changes are ignored
      run_period(5, 0, 100, 0, "R6");
      run_period(40, 3, 1000, 0, "R6_R5");
      run_period(0, 1, 7, 0, "R6_R2");
      // R7: standby mid-period, inputs ignored while halted
      run_period(62, 0, -1, 200, "R7");
      standby = 1'b1;
      for (int i = 0; i < 30; i++) begin
         duty_code = 6'(i * 7);
         cyc(1'b0, "R7");
      end
      standby = 1'b0;
      run_period(10, 0, -1, 0, "R7");
      // R1, R8: reset mid-period then restart
      run_period(50, 1, -1, 300, "R3");
      rst = 1'b1;
      for (int i = 0; i < 3; i++) cyc(1'b0, "R1");
      rst = 1'b0;
      run_period(3, 0, -1, 0, "R8");
      run_period(63, 0, -1, 0, "R4");
      while (q.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      finish_sim();
   end
endmodule